// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block sits between a pulse-width modulator and the two gate drivers of a synchronous buck half-bridge. A single PWM level comes in and two gate enables go out: the high-side enable follows the PWM level, and the low-side enable follows its inverse. The block inserts dead time at both transitions so that the two switches are never commanded on together.

Turning the low side on is adaptive. The sequencer records whether the switch node rose while the high side was on. If it did, the low side waits for the switch node to drop below 1 V. If it did not, the low side waits a fixed time instead. In either case, a timeout turns the low side on if the node never falls. Turning the high side on waits for a flag saying the low-side gate has fallen below one sixth of the supply, then adds a fixed extra delay.

An active-low enable gates both outputs off at once. All comparator flags, the PWM level and the enable are first resynchronised to the clock. All delays are given in nanoseconds and converted to clock cycles from the clock-period parameter, rounding up.

Top module: `deadtime_seq`

## Requirements
- R1: `hs_on_o` and `ls_on_o` are never both 1.
- R2: While `enable_i` is 0, both outputs are 0. This takes effect in the same cycle `enable_i` falls and holds whatever the PWM level.
- R3: Every input passes through a two-flop synchronizer. A change on `pwm_i` therefore first shows on the output being switched off at the third rising clock edge after the change.
- R4: Suppose `sw_high_i` was seen as 1 while the high side was on. After the high side turns off, `ls_on_o` then rises on the third edge after `sw_below1v_i` goes to 1, provided this comes before the timeout.
- R5: If `sw_high_i` was not seen as 1 during the high-side on period, `ls_on_o` rises exactly ceil(LS_FIXED_NS / CLK_PERIOD_NS) cycles after `hs_on_o` falls. In this case `sw_below1v_i` is ignored.
- R6: If the switch node was seen high but `sw_below1v_i` has not been seen, `ls_on_o` rises ceil(LS_TIMEOUT_NS / CLK_PERIOD_NS) cycles after `hs_on_o` falls.
- R7: After `ls_on_o` falls, `hs_on_o` stays 0 until `lsg_below_i` is seen as 1. It then rises ceil(HS_EXTRA_NS / CLK_PERIOD_NS) cycles after the synchronized flag is first acted on, which is 8 cycles after the flag input rises for a 125 MHz clock.
- R8: If PWM reverses during a dead-time wait, the pending turn-on is dropped and the opposite sequence starts. The output forbidden by the new PWM level never asserts.
- R9: After the enable returns, the sequencer restarts from the both-off state and applies the same gate-flag check before any high-side turn-on.
- R10: During reset both outputs are 0. After reset, with PWM low and the enable high, `ls_on_o` rises through the fixed-delay path, 18 cycles after reset release at a 125 MHz clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_i | input | 1 | PWM command, 1 = high side on |
| enable_i | input | 1 | Active-low output disable; 0 forces both gates off |
| sw_high_i | input | 1 | Comparator flag: switch node is high |
| sw_below1v_i | input | 1 | Comparator flag: switch node is below 1 V |
| lsg_below_i | input | 1 | Comparator flag: low-side gate is below one sixth of supply |
| hs_on_o | output | 1 | High-side gate enable |
| ls_on_o | output | 1 | Low-side gate enable |

## Verification
The bench builds the block with an 8 ns clock period and default delays. This gives 15 cycles for the fixed low-side delay, 30 cycles for the timeout and 5 cycles for the extra high-side delay. These counts are short enough that every exit from the low-side wait can be measured to the exact cycle: a fall of the switch node just before, exactly at, and after the timeout, as well as the rising-edge-free path. Reversals of PWM inside each wait and re-entry after the disable are also reached within a few dozen cycles.

// File: rtl/dts_pkg.sv
package dts_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HS_GATE = 3'd1,
    ST_HS_DLY  = 3'd2,
    ST_HS_ON   = 3'd3,
    ST_LS_WAIT = 3'd4,
    ST_LS_ON   = 3'd5
  } dts_state_e;

  // Round a delay in ns up to whole clock cycles, never below one.
  function automatic int ns2cyc(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/dts_sync.sv
module dts_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end

endmodule

// File: rtl/dts_delay.sv
module dts_delay #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          done
);

  logic          dec_en;
  logic [CW-1:0] count_nxt;

  assign done   = (count == '0);
  assign dec_en = !load && !done;

  always_comb begin
    count_nxt = count;
    if (load)        count_nxt = load_val;
    else if (dec_en) count_nxt = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count_nxt;
  end

  // R5/R6/R7: every wait counts down by exactly one per cycle
  a_r6_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count != '0) |=> (count == CW'($past(count) - 1'b1)));

  a_r7_hold_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count == '0) |=> (count == '0));

endmodule

// File: rtl/dts_fsm.sv
module dts_fsm
  import dts_pkg::*;
#(
  parameter int CW       = 5,
  parameter int FIX_CYC  = 12,
  parameter int TMO_CYC  = 24,
  parameter int HSD_CYC  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_s,
  input  logic          pwm_s,
  input  logic          sw_high_s,
  input  logic          sw_low_s,
  input  logic          lsg_low_s,
  input  logic          cnt_done,
  output logic          cnt_load,
  output logic [CW-1:0] cnt_val,
  output logic          hs_q,
  output logic          ls_q
);

  localparam logic [CW-1:0] FIX_LD = CW'(FIX_CYC - 1);
  localparam logic [CW-1:0] TMO_LD = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] HSD_LD = CW'(HSD_CYC - 1);

  dts_state_e st, st_nxt;
  logic       seen_high, seen_high_nxt;

  always_comb begin
    st_nxt        = st;
    seen_high_nxt = seen_high;
    cnt_load      = 1'b0;
    cnt_val       = '0;
    if (!en_s) begin
      st_nxt        = ST_IDLE;
      seen_high_nxt = 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          seen_high_nxt = 1'b0;
          if (pwm_s) begin
            st_nxt = ST_HS_GATE;
          end else begin
            st_nxt   = ST_LS_WAIT;
            cnt_load = 1'b1;
            cnt_val  = FIX_LD;
          end
        end
        ST_HS_GATE: begin
          if (!pwm_s) begin
            st_nxt   = ST_LS_WAIT;
            cnt_load = 1'b1;
            cnt_val  = FIX_LD;
          end else if (lsg_low_s) begin
            st_nxt   = ST_HS_DLY;
            cnt_load = 1'b1;
            cnt_val  = HSD_LD;
          end
        end
        ST_HS_DLY: begin
          if (!pwm_s) begin
            st_nxt   = ST_LS_WAIT;
            cnt_load = 1'b1;
            cnt_val  = FIX_LD;
          end else if (cnt_done) begin
            st_nxt = ST_HS_ON;
          end
        end
        ST_HS_ON: begin
          if (sw_high_s) seen_high_nxt = 1'b1;
          if (!pwm_s) begin
            st_nxt   = ST_LS_WAIT;
            cnt_load = 1'b1;
            cnt_val  = (seen_high || sw_high_s) ? TMO_LD : FIX_LD;
          end
        end
        ST_LS_WAIT: begin
          if (pwm_s) begin
            st_nxt        = ST_HS_GATE;
            seen_high_nxt = 1'b0;
          end else if ((seen_high && sw_low_s) || cnt_done) begin
            st_nxt = ST_LS_ON;
          end
        end
        ST_LS_ON: begin
          if (pwm_s) begin
            st_nxt        = ST_HS_GATE;
            seen_high_nxt = 1'b0;
          end
        end
        default: begin
          st_nxt        = ST_IDLE;
          seen_high_nxt = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      seen_high <= 1'b0;
    end else begin
      st        <= st_nxt;
      seen_high <= seen_high_nxt;
    end
  end

  assign hs_q = (st == ST_HS_ON);
  assign ls_q = (st == ST_LS_ON);

  // R9: a disabled sequencer parks in the both-off state
  a_r9_park_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (st == ST_IDLE));

  // R4/R5/R6: the low side only starts at the end of a wait, for a valid cause
  a_r4_ls_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> ($past(st) == ST_LS_WAIT) &&
                    ($past(cnt_done) || ($past(seen_high) && $past(sw_low_s))));

  // R7: the high side only starts once the extra delay has run out
  a_r7_hs_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> ($past(st) == ST_HS_DLY) && $past(cnt_done));

  // R8: never start the side the current PWM level forbids
  a_r8_hs_needs_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_q) |-> $past(pwm_s));

  a_r8_ls_needs_no_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_q) |-> !$past(pwm_s));

endmodule

// File: rtl/deadtime_seq.sv
module deadtime_seq
  import dts_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int LS_FIXED_NS   = 120,
  parameter int LS_TIMEOUT_NS = 240,
  parameter int HS_EXTRA_NS   = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic enable_i,
  input  logic sw_high_i,
  input  logic sw_below1v_i,
  input  logic lsg_below_i,
  output logic hs_on_o,
  output logic ls_on_o
);

  localparam int FIX_CYC = ns2cyc(LS_FIXED_NS, CLK_PERIOD_NS);
  localparam int TMO_CYC = ns2cyc(LS_TIMEOUT_NS, CLK_PERIOD_NS);
  localparam int HSD_CYC = ns2cyc(HS_EXTRA_NS, CLK_PERIOD_NS);
  localparam int MAX_CYC = max3(FIX_CYC, TMO_CYC, HSD_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);
  localparam int NSYNC   = 5;

  logic [NSYNC-1:0] raw_in, sync_in;
  logic             en_s, pwm_s, sw_high_s, sw_low_s, lsg_low_s;
  logic             cnt_load, cnt_done;
  logic [CW-1:0]    cnt_val, cnt_q;
  logic             hs_q, ls_q;

  assign raw_in = {enable_i, pwm_i, sw_high_i, sw_below1v_i, lsg_below_i};
  assign {en_s, pwm_s, sw_high_s, sw_low_s, lsg_low_s} = sync_in;

  dts_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_in),
    .q     (sync_in)
  );

  dts_delay #(.CW(CW)) u_delay (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .count    (cnt_q),
    .done     (cnt_done)
  );

  dts_fsm #(
    .CW      (CW),
    .FIX_CYC (FIX_CYC),
    .TMO_CYC (TMO_CYC),
    .HSD_CYC (HSD_CYC)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .pwm_s     (pwm_s),
    .sw_high_s (sw_high_s),
    .sw_low_s  (sw_low_s),
    .lsg_low_s (lsg_low_s),
    .cnt_done  (cnt_done),
    .cnt_load  (cnt_load),
    .cnt_val   (cnt_val),
    .hs_q      (hs_q),
    .ls_q      (ls_q)
  );

  // R2: the raw enable bypasses the synchronizer so shutdown is immediate
  assign hs_on_o = hs_q && enable_i;
  assign ls_on_o = ls_q && enable_i;

  // R1: both gates never on together
  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on_o && ls_on_o));

  // R8: a change of side always passes a cycle with both gates off
  a_r8_gap_on_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on_o) |-> !$past(ls_on_o));

endmodule

// File: tb/deadtime_seq_bench.sv
module deadtime_seq_bench;

  typedef struct packed {
    logic       rise;    // switch node driven high during high-side on
    logic [7:0] fall;    // cycle after hs turn-off when node drops below 1 V (255 = never)
    logic [3:0] gwait;   // cycles after ls turn-off until low-side gate flag sets
    logic [7:0] exp_ls;  // expected cycles from hs fall to ls rise
    logic [7:0] exp_hs;  // expected cycles from ls fall to hs rise
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'd0,   4'd0, 8'd3,  8'd8},
    '{1'b1, 8'd5,   4'd2, 8'd8,  8'd10},
    '{1'b1, 8'd20,  4'd1, 8'd23, 8'd9},
    '{1'b1, 8'd27,  4'd0, 8'd30, 8'd8},
    '{1'b1, 8'd255, 4'd3, 8'd30, 8'd11},
    '{1'b0, 8'd0,   4'd0, 8'd15, 8'd8},
    '{1'b0, 8'd255, 4'd4, 8'd15, 8'd12},
    '{1'b1, 8'd40,  4'd0, 8'd30, 8'd8}
  };

  logic clk, rst_n, pwm, en, sw_hi, sw_lo, lsg_lo;
  logic hs_on, ls_on;
  int   checks, failures, overlaps, cyc;
  bit   done, seen_hs, seen_ls;
  vec_t v;
  string tag;

  deadtime_seq #(.CLK_PERIOD_NS(8)) u_deadtime_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .pwm_i        (pwm),
    .enable_i     (en),
    .sw_high_i    (sw_hi),
    .sw_below1v_i (sw_lo),
    .lsg_below_i  (lsg_lo),
    .hs_on_o      (hs_on),
    .ls_on_o      (ls_on)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n && hs_on && ls_on) overlaps++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; overlaps = 0; done = 1'b0;
    rst_n = 1'b0; pwm = 1'b0; en = 1'b1; sw_hi = 1'b0; sw_lo = 1'b1; lsg_lo = 1'b0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10 hs in reset", int'(hs_on), 0);
    chk("R10 ls in reset", int'(ls_on), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!ls_on && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R10 ls start-up delay", cyc, 18);
    repeat (3) @(negedge clk);

    // table of delay paths
    for (int i = 0; i < NVEC; i++) begin
      v = VECS[i];
      pwm = 1'b1;
      cyc = 0;
      while (ls_on && cyc < 50) begin @(negedge clk); cyc++; end
      chk("R3 ls drop after pwm rise", cyc, 3);
      if (v.gwait == 4'd0) lsg_lo = 1'b1;
      cyc = 0;
      while (!hs_on && cyc < 80) begin
        @(negedge clk); cyc++;
        if (cyc == int'(v.gwait)) lsg_lo = 1'b1;
      end
      chk("R7 hs delay after gate flag", cyc, int'(v.exp_hs));
      if (v.rise) begin sw_hi = 1'b1; sw_lo = 1'b0; end
      repeat (6) @(negedge clk);
      pwm = 1'b0;
      cyc = 0;
      while (hs_on && cyc < 50) begin @(negedge clk); cyc++; end
      chk("R3 hs drop after pwm fall", cyc, 3);
      chk("R1 ls off as hs drops", int'(ls_on), 0);
      if (v.fall == 8'd0) begin sw_hi = 1'b0; sw_lo = 1'b1; end
      cyc = 0;
      while (!ls_on && cyc < 100) begin
        @(negedge clk); cyc++;
        if (cyc == int'(v.fall)) begin sw_hi = 1'b0; sw_lo = 1'b1; end
      end
      if (!v.rise)                          tag = "R5 fixed low-side delay";
      else if (int'(v.fall) + 3 >= 30)      tag = "R6 low-side timeout";
      else                                  tag = "R4 adaptive low-side";
      chk(tag, cyc, int'(v.exp_ls));
      sw_hi = 1'b0; sw_lo = 1'b1; lsg_lo = 1'b0;
      repeat (3) @(negedge clk);
    end

    // R8: reversal while waiting for the gate flag
    pwm = 1'b1;
    cyc = 0;
    while (ls_on && cyc < 50) begin @(negedge clk); cyc++; end
    seen_hs = 1'b0;
    repeat (5) begin @(negedge clk); if (hs_on) seen_hs = 1'b1; end
    chk("R7 hs held without gate flag", int'(seen_hs), 0);
    pwm = 1'b0;
    cyc = 0;
    while (!ls_on && cyc < 100) begin
      @(negedge clk); cyc++;
      if (hs_on) seen_hs = 1'b1;
    end
    chk("R8 ls after reversal in gate wait", cyc, 18);
    chk("R8 hs never on in reversal", int'(seen_hs), 0);
    repeat (3) @(negedge clk);

    // R8: reversal while waiting for the low side
    pwm = 1'b1;
    cyc = 0;
    while (ls_on && cyc < 50) begin @(negedge clk); cyc++; end
    lsg_lo = 1'b1;
    while (!hs_on && cyc < 100) begin @(negedge clk); cyc++; end
    sw_hi = 1'b1; sw_lo = 1'b0;
    repeat (6) @(negedge clk);
    pwm = 1'b0;
    cyc = 0;
    while (hs_on && cyc < 50) begin @(negedge clk); cyc++; end
    seen_ls = 1'b0;
    repeat (2) begin @(negedge clk); if (ls_on) seen_ls = 1'b1; end
    pwm = 1'b1;
    cyc = 0;
    while (!hs_on && cyc < 100) begin
      @(negedge clk); cyc++;
      if (ls_on) seen_ls = 1'b1;
    end
    chk("R8 hs after reversal in low-side wait", cyc, 9);
    chk("R8 ls never on in reversal", int'(seen_ls), 0);

    // R2: immediate disable, held whatever pwm does
    @(negedge clk);
    en = 1'b0;
    #1;
    chk("R2 hs off at disable", int'(hs_on), 0);
    chk("R2 ls off at disable", int'(ls_on), 0);
    sw_hi = 1'b0; sw_lo = 1'b1; lsg_lo = 1'b0;
    seen_hs = 1'b0; seen_ls = 1'b0;
    pwm = 1'b0;
    repeat (20) begin @(negedge clk); if (hs_on) seen_hs = 1'b1; if (ls_on) seen_ls = 1'b1; end
    pwm = 1'b1;
    repeat (20) begin @(negedge clk); if (hs_on) seen_hs = 1'b1; if (ls_on) seen_ls = 1'b1; end
    chk("R2 hs held off while disabled", int'(seen_hs), 0);
    chk("R2 ls held off while disabled", int'(seen_ls), 0);

    // R9: re-enable with pwm high goes through the gate-flag check
    en = 1'b1;
    seen_hs = 1'b0;
    repeat (10) begin @(negedge clk); if (hs_on) seen_hs = 1'b1; end
    chk("R9 hs waits for gate flag after enable", int'(seen_hs), 0);
    lsg_lo = 1'b1;
    cyc = 0;
    while (!hs_on && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R9 hs delay after enable", cyc, 8);

    chk("R1 overlap cycles", overlaps, 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule